// File: doc/BRIEF.md
# Two-Operand ALU with Status Flag Logic

This block is the arithmetic and logic stage of a 16-bit microcontroller datapath. Each accepted operation takes a 4-bit operation code, a byte/word selector, a source operand, a destination operand and an incoming carry. One clock later the block presents a result, a write-back enable, new values for the V, N, Z and C status bits, and a mask that marks which of those bits the operation actually updates. The surrounding core merges the flag values into its status register under that mask. It also uses the write-back enable to decide whether the destination is stored.

The supported operations are move, binary add and subtract (each with and without carry-in), compare, packed-BCD decimal add, bit test, bit clear, bit set, exclusive-or and and. Each operation follows its own flag rule. Some operations leave every flag alone. Some force V to zero. The logical operations derive C as the inverse of Z. Subtraction is performed as an addition of the inverted source. In byte mode only the low half of the data path is meaningful, and every flag is taken from the 8-bit operation.

Top module: `alu2op`

## Requirements
- R1: Operation codes are 0 move, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-carry, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 xor and 11 and. Move writes src. Bit clear writes (NOT src) AND dst. Bit set writes src OR dst. All three assert write-back and give a flag mask of 0000.
- R2: Add writes dst+src, and add-with-carry writes dst+src+c_in. Both have mask 1111. C is the carry out of the operand's top bit. V is set when both addends have the same sign and the result's sign differs from it.
- R3: Subtract writes dst+(NOT src)+1, and subtract-with-carry writes dst+(NOT src)+c_in. Both have mask 1111, with C and V derived from that addition as in R2.
- R4: Compare produces the same flags and mask as subtract, but write-back is deasserted.
- R5: Decimal add treats each 4-bit group as a digit and adds src+dst+c_in digit by digit. A digit sum above 9 has 6 added and keeps only its low 4 bits, and it passes a carry into the next digit. C is the carry out of the top digit, V is 0 and the mask is 1111.
- R6: Bit test and and both compute src AND dst with mask 1111, V = 0 and C = NOT Z. Only and asserts write-back.
- R7: Xor writes src XOR dst with mask 1111. V is set when both operands have their sign bit set, and C = NOT Z.
- R8: When byte_mode is 1, only the low 8 bits are computed and the high 8 result bits are zero. N is result bit 7, and C and V come from the 8-bit operation. Z refers to the low byte only.
- R9: Flags and mask use the bit order {V,N,Z,C} (bit 3 down to bit 0). N is the result's sign bit and Z is set when the result is zero. Flag bits outside the mask are 0.
- R10: Outputs are registered. out_valid follows in_valid by one clock. Result, write-back, flags and mask change only when in_valid is 1, and they all reset to 0.
- R11: Operation codes 12 to 15 yield result 0, no write-back and mask 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| c_in | input | 1 | Incoming carry |
| out_valid | output | 1 | Registered result is new |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Store result to destination |
| flags | output | 4 | New {V,N,Z,C} values |
| flag_mask | output | 4 | Which of {V,N,Z,C} are updated |

## Verification
The bench builds the block with the default width W = 16. This gives four decimal digits in word mode and two in byte mode, so digit carry chains that run through every digit can be checked (for example 9999 + 1), along with both the 8-bit and 16-bit carry and overflow positions. Directed corner cases cover signed overflow at both widths, equal-operand subtraction, full decimal wrap, zero bit tests, xor of two negatives and undefined codes. Several hundred random operations follow, with decimal operands restricted to valid BCD, and each one is compared against a behavioural model on every clock.

// File: rtl/alu2op.sv
module alu2op #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         c_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags,
  output logic [3:0]   flag_mask
);
  localparam int H  = W / 2;
  localparam int ND = W / 4;
  localparam int NB = H / 4;

  localparam logic [3:0] OP_MOV = 4'd0, OP_ADD = 4'd1, OP_ADDC = 4'd2,
                         OP_SUB = 4'd3, OP_SUBC = 4'd4, OP_CMP = 4'd5,
                         OP_DADD = 4'd6, OP_BIT = 4'd7, OP_BIC = 4'd8,
                         OP_BIS = 4'd9, OP_XOR = 4'd10, OP_AND = 4'd11;

  logic is_sub;
  assign is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);

  logic [W-1:0] bop;
  logic         cin_eff;
  assign bop     = is_sub ? ~src : src;
  assign cin_eff = (op == OP_SUB || op == OP_CMP) ? 1'b1 :
                   (op == OP_ADDC || op == OP_SUBC) ? c_in : 1'b0;

  logic [H:0] lo_sum, hi_sum;
  assign lo_sum = {1'b0, dst[H-1:0]} + {1'b0, bop[H-1:0]} + {{H{1'b0}}, cin_eff};
  assign hi_sum = {1'b0, dst[W-1:H]} + {1'b0, bop[W-1:H]} + {{H{1'b0}}, lo_sum[H]};

  logic [W-1:0] add_res;
  logic         add_c;
  assign add_res = {hi_sum[H-1:0], lo_sum[H-1:0]};
  assign add_c   = byte_mode ? lo_sum[H] : hi_sum[H];

  logic [ND:0]  dcy;
  logic [W-1:0] dec_res;
  assign dcy[0] = c_in;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [4:0] s5;
    logic       over;
    assign s5   = {1'b0, src[4*i +: 4]} + {1'b0, dst[4*i +: 4]} + {4'd0, dcy[i]};
    assign over = s5 > 5'd9;
    assign dec_res[4*i +: 4] = over ? (s5[3:0] + 4'd6) : s5[3:0];
    assign dcy[i+1] = over;
  end

  logic dec_c;
  assign dec_c = byte_mode ? dcy[NB] : dcy[ND];

  logic [W-1:0] raw, rm;
  logic         we, n_f, z_f, ma, mb;
  logic [3:0]   fl, mk;

  always_comb begin
    raw = '0;
    we  = 1'b0;
    case (op)
      OP_MOV:                            begin raw = src;          we = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC:  begin raw = add_res;      we = 1'b1; end
      OP_CMP:                            raw = add_res;
      OP_DADD:                           begin raw = dec_res;      we = 1'b1; end
      OP_BIT:                            raw = src & dst;
      OP_BIC:                            begin raw = ~src & dst;   we = 1'b1; end
      OP_BIS:                            begin raw = src | dst;    we = 1'b1; end
      OP_XOR:                            begin raw = src ^ dst;    we = 1'b1; end
      OP_AND:                            begin raw = src & dst;    we = 1'b1; end
      default: ;
    endcase
  end

  assign rm  = byte_mode ? {{(W-H){1'b0}}, raw[H-1:0]} : raw;
  assign n_f = byte_mode ? rm[H-1] : rm[W-1];
  assign z_f = (rm == '0);
  assign ma  = byte_mode ? dst[H-1] : dst[W-1];
  assign mb  = byte_mode ? bop[H-1] : bop[W-1];

  always_comb begin
    fl = 4'b0000;
    mk = 4'b0000;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        fl = {(ma == mb) && (n_f != ma), n_f, z_f, add_c};
        mk = 4'b1111;
      end
      OP_DADD: begin
        fl = {1'b0, n_f, z_f, dec_c};
        mk = 4'b1111;
      end
      OP_BIT, OP_AND: begin
        fl = {1'b0, n_f, z_f, ~z_f};
        mk = 4'b1111;
      end
      OP_XOR: begin
        fl = {byte_mode ? (src[H-1] & dst[H-1]) : (src[W-1] & dst[W-1]), n_f, z_f, ~z_f};
        mk = 4'b1111;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flags     <= 4'b0000;
      flag_mask <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= rm;
        wr_en     <= we;
        flags     <= fl;
        flag_mask <= mk;
      end
    end
  end
endmodule

module alu2op_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic         byte_mode,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags,
  input logic [3:0]   flag_mask
);
  localparam int H = W / 2;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flags));
  assert_no_write_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd5 |=> !wr_en && flag_mask == 4'b1111);
  assert_untouched_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 4'd0 || op == 4'd8 || op == 4'd9) |=> wr_en && flag_mask == 4'b0000);
  assert_carry_not_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 4'd7 || op == 4'd11) |=> flags[0] == !flags[1] && !flags[3]);
  assert_carry_not_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd10 |=> flags[0] == !flags[1]);
  assert_dec_v_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd6 |=> !flags[3]);
  assert_high_byte_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && byte_mode |=> result[W-1:H] == '0);
  assert_masked_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags & ~flag_mask) == 4'b0000);
  assert_undefined_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 4'd12 |=> !wr_en && flag_mask == 4'b0000 && result == '0);
endmodule

bind alu2op alu2op_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
  .out_valid(out_valid), .result(result), .wr_en(wr_en), .flags(flags),
  .flag_mask(flag_mask)
);

// File: tb/sim_alu2op.sv
module sim_alu2op;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] src = 16'd0, dst = 16'd0;
  logic        c_in = 1'b0;
  logic        out_valid, wr_en;
  logic [15:0] result;
  logic [3:0]  flags, flag_mask;

  int compared = 0, mismatched = 0;

  alu2op #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
    .src(src), .dst(dst), .c_in(c_in), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .flags(flags), .flag_mask(flag_mask)
  );

  always #10 clk = ~clk;

  function automatic string tag_of(input int o, input bit bw);
    if (bw && o < 12) return "R8";
    case (o)
      0, 8, 9: return "R1";
      1, 2:    return "R2";
      3, 4:    return "R3";
      5:       return "R4";
      6:       return "R5";
      7, 11:   return "R6";
      10:      return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int o, input bit bw, input int s, input int d, input int c,
                       output int r, output bit we, output int fl, output int mk);
    int w, m, msb, a, b, t, v, cy, x;
    bit n, z, cf;
    w = bw ? 8 : 16;
    m = (1 << w) - 1;
    msb = 1 << (w - 1);
    a = s & m;
    b = d & m;
    r = 0; we = 0; v = 0; cf = 0; mk = 0;
    case (o)
      0: begin r = a; we = 1; end
      8: begin r = (~a) & b & m; we = 1; end
      9: begin r = a | b; we = 1; end
      1, 2, 3, 4, 5: begin
        if (o >= 3) a = (~a) & m;
        t = b + a + ((o == 3 || o == 5) ? 1 : (o == 2 || o == 4) ? c : 0);
        r = t & m;
        cf = ((t >> w) & 1) != 0;
        v = (((a & msb) == (b & msb)) && ((r & msb) != (a & msb))) ? 1 : 0;
        we = (o != 5);
        mk = 15;
      end
      6: begin
        cy = c;
        for (int i = 0; i < w / 4; i++) begin
          x = ((a >> (4 * i)) & 15) + ((b >> (4 * i)) & 15) + cy;
          if (x > 9) begin x = (x + 6) & 15; cy = 1; end else cy = 0;
          r = r | (x << (4 * i));
        end
        cf = cy != 0;
        we = 1; mk = 15;
      end
      7, 11: begin r = a & b; we = (o == 11); mk = 15; end
      10: begin
        r = a ^ b; we = 1; mk = 15;
        v = ((a & msb) != 0 && (b & msb) != 0) ? 1 : 0;
      end
      default: ;
    endcase
    n = (r & msb) != 0;
    z = r == 0;
    if (o == 7 || o == 10 || o == 11) cf = !z;
    fl = (mk == 15) ? ((v << 3) | (int'(n) << 2) | (int'(z) << 1) | int'(cf)) : 0;
  endtask

  bit        have_prev = 0;
  bit        prev_valid;
  int        e_r, e_fl, e_mk;
  bit        e_we;
  string     e_tag;

  task automatic compare_prev();
    compared++;
    if (out_valid !== prev_valid) begin
      mismatched++;
      $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, prev_valid);
    end else if (prev_valid) begin
      if (result !== e_r[15:0] || wr_en !== e_we || flags !== e_fl[3:0] || flag_mask !== e_mk[3:0]) begin
        mismatched++;
        $display("FAIL %s actual r=%h we=%0b f=%b m=%b expected r=%h we=%0b f=%b m=%b",
                 e_tag, result, wr_en, flags, flag_mask, e_r[15:0], e_we, e_fl[3:0], e_mk[3:0]);
      end
    end
  endtask

  task automatic step(input bit v, input int o, input bit bw, input int s, input int d, input bit c);
    @(negedge clk);
    if (have_prev) compare_prev();
    in_valid = v; op = 4'(o); byte_mode = bw; src = 16'(s); dst = 16'(d); c_in = c;
    prev_valid = v;
    if (v) begin
      model(o, bw, s, d, c, e_r, e_we, e_fl, e_mk);
      e_tag = tag_of(o, bw);
    end
    have_prev = 1;
  endtask

  function automatic int rand_bcd();
    int r = 0;
    for (int i = 0; i < 4; i++) r = r | (($urandom % 10) << (4 * i));
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 0 || result !== 0 || wr_en !== 0 || flags !== 0 || flag_mask !== 0) begin
      mismatched++;
      $display("FAIL R10 reset outputs actual v=%0b r=%h we=%0b f=%b m=%b expected all zero",
               out_valid, result, wr_en, flags, flag_mask);
    end
    rst_n = 1'b1;
    step(1, 1, 0, 16'h0001, 16'h7FFF, 0);   // R2 signed overflow
    step(1, 2, 0, 16'hFFFF, 16'h0000, 1);   // R2 carry out, zero
    step(1, 1, 1, 16'h0001, 16'h007F, 0);   // R8 byte overflow
    step(1, 3, 0, 16'h1234, 16'h1234, 0);   // R3 equal -> Z,C
    step(1, 4, 1, 16'h0001, 16'h0080, 0);   // R8 byte subtract with borrow
    step(1, 5, 0, 16'h0002, 16'h0001, 0);   // R4 compare no write
    step(1, 6, 0, 16'h0001, 16'h9999, 0);   // R5 full wrap
    step(1, 6, 0, 16'h0001, 16'h0999, 0);   // R5 ripple
    step(1, 6, 1, 16'h0055, 16'h1245, 1);   // R8 byte decimal
    step(1, 7, 0, 16'h00F0, 16'h0F0F, 0);   // R6 zero test
    step(0, 0, 0, 0, 0, 0);                 // R10 idle
    step(1, 10, 0, 16'h8000, 16'h8001, 0);  // R7 both negative
    step(1, 11, 1, 16'hFF80, 16'hFF80, 0);  // R8 and byte
    step(1, 0, 1, 16'h1234, 16'hFFFF, 1);   // R8 move byte
    step(1, 8, 0, 16'h0F0F, 16'hFFFF, 0);   // R1 bit clear
    step(1, 9, 0, 16'h0F00, 16'h00F0, 0);   // R1 bit set
    step(1, 13, 0, 16'h1111, 16'h2222, 1);  // R11 undefined
    for (int k = 0; k < 600; k++) begin
      int o = $urandom % 16;
      int s = $urandom & 16'hFFFF;
      int d = $urandom & 16'hFFFF;
      if (o == 6) begin s = rand_bcd(); d = rand_bcd(); end
      step(($urandom % 8) != 0, o, ($urandom % 3) == 0, s, d, $urandom % 2);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R10 watchdog actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule